// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Level Flags

This block is a small first-in first-out buffer between a write clock domain and a read clock domain. Words enter through an active-low write enable on the write clock and leave through an active-low read enable on the read clock. A single mode input, sampled only while master reset is held, picks one of two read timings. In standard timing a read enable pulse loads the next word into the output register. In fall-through timing the oldest word is presented on the output as soon as it is available, and read enable acknowledges it.

The same mode bit redefines the two handshake flags. In standard timing they report "empty" (read side) and "full" (write side). In fall-through timing they report "word valid on output" and "room for a write". Three level flags (half-full, almost-empty, almost-full) are driven in both timings. The almost-empty and almost-full thresholds arrive as inputs from a separate offset-register block.

Pointers cross domains as Gray code through two-flop synchronizers. Master reset clears both pointers and latches the mode. Partial reset clears both pointers but keeps the latched mode, so the flags are re-evaluated under the retained timing and offsets. The read side is a three-state machine. `RD_STD` is standard timing: a read fetches a word when one is stored. `RD_DRAINED` is fall-through timing with nothing on the output; it moves to `RD_HOLD` as soon as a word is stored. `RD_HOLD` is fall-through timing with a valid word held on the output. A read in `RD_HOLD` fetches the next word and stays there, or returns to `RD_DRAINED` when storage is empty. Either reset sends the machine to `RD_STD` or `RD_DRAINED`, according to the latched mode.

Top module: `dm_fifo`

## Requirements
- R1: The timing mode is taken from `fwft_sel` on every write- and read-clock edge at which `mrs_n` is low (0 = standard, 1 = fall-through); changes of `fwft_sel` at any other time have no effect.
- R2: In standard timing, `rd_flag` is 1 exactly when the FIFO holds no word. A read-clock edge with `ren_n` low and a word stored loads the oldest word onto `dout`.
- R3: In fall-through timing, the first word written into an empty FIFO appears on `dout` with `rd_flag` = 1 and no read enable asserted.
- R4: In fall-through timing, each later word needs a read-clock edge with `ren_n` low. When the last word is acknowledged, `rd_flag` drops to 0 and `dout` keeps that last word.
- R5: `wr_flag` is 1 when full in standard timing, and 1 when not full (room for a write) in fall-through timing. Full means the stored count, excluding a word held on the fall-through output, equals DEPTH, so fall-through timing holds DEPTH+1 words.
- R6: A write while full and a standard-timing read while empty are ignored. No word is lost or added, and `dout` is unchanged.
- R7: `half_full` is 1 when the stored count (as in R5) is greater than DEPTH/2.
- R8: `almost_empty` is 1 when the total count, including a word held on the fall-through output, is at most `ae_off`.
- R9: `almost_full` is 1 when the stored count (as in R5) is at least DEPTH minus `af_off`.
- R10: Master reset (`mrs_n` low on both clocks) empties the FIFO and sets `dout` to 0. The flags then show the empty state of the selected mode.
- R11: Partial reset (`prs_n` low on both clocks) empties the FIFO and keeps the latched mode, so later writes follow the retained timing.
- R12: Words leave in the order written. Each cross-domain pointer changes at most one Gray-code bit per clock outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write enable, active low |
| din | input | WIDTH | Write data |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Read enable, active low |
| dout | output | WIDTH | Output data register |
| mrs_n | input | 1 | Master reset, synchronous, active low, on both clocks |
| prs_n | input | 1 | Partial reset, synchronous, active low, on both clocks |
| fwft_sel | input | 1 | Timing mode, sampled during master reset |
| ae_off | input | ADDR_W+1 | Almost-empty threshold |
| af_off | input | ADDR_W+1 | Almost-full threshold |
| rd_flag | output | 1 | Empty (standard) or output-valid (fall-through) |
| wr_flag | output | 1 | Full (standard) or room-available (fall-through) |
| half_full | output | 1 | Count above half the depth |
| almost_empty | output | 1 | Total count at or below `ae_off` |
| almost_full | output | 1 | Count at or above DEPTH minus `af_off` |

## Verification
Both timings are exercised with fill patterns that stop at each flag boundary: 3/4 words for almost-empty, 8/9 for half-full, 13/14 for almost-full, and full plus extra writes. Each point separates an off-by-one threshold from a correct one. Drains in standard timing are done one word at a time, and drains in fall-through timing back-to-back. This compares the output register with a behavioural queue and separates a lost, repeated or reordered word from a flag error. Reads on an empty FIFO, mode toggles outside master reset, and a partial reset taken on a half-filled fall-through FIFO show whether ignored stimuli and retained state are honoured.

// File: rtl/dm_fifo_pkg.sv
package dm_fifo_pkg;

    typedef enum logic [1:0] {
        RD_STD     = 2'd0,
        RD_DRAINED = 2'd1,
        RD_HOLD    = 2'd2
    } rd_state_e;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g, input int unsigned w);
        logic [31:0] b;
        b = '0;
        for (int i = 31; i >= 0; i--) begin
            if (i < int'(w)) begin
                b[i] = g[i] ^ ((i == int'(w) - 1) ? 1'b0 : b[i+1]);
            end
        end
        return b;
    endfunction

endpackage

// File: rtl/dm_fifo_sync2.sv
module dm_fifo_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (clr) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dm_fifo_wr_ctrl.sv
module dm_fifo_wr_ctrl
    import dm_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              mrs_n,
    input  logic              prs_n,
    input  logic              fwft_sel,
    input  logic              wen_n,
    input  logic [PTR_W-1:0]  rgray_sync,
    input  logic [PTR_W-1:0]  af_off,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wgray,
    output logic              wr_flag,
    output logic              half_full,
    output logic              almost_full
);
    localparam int HALF = DEPTH / 2;
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

    logic             fwft_q;
    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] rbin_sync;
    logic [PTR_W-1:0] wlevel;
    logic             full;

    always_ff @(posedge wclk) begin
        if (!mrs_n) begin
            fwft_q <= fwft_sel;
            wbin   <= '0;
            wgray  <= '0;
        end else if (!prs_n) begin
            wbin   <= '0;
            wgray  <= '0;
        end else if (we) begin
            wbin   <= wbin + 1'b1;
            wgray  <= PTR_W'(bin2gray(32'(wbin + 1'b1)));
        end
    end

    always_comb begin
        rbin_sync   = PTR_W'(gray2bin(32'(rgray_sync), PTR_W));
        wlevel      = wbin - rbin_sync;
        full        = (wlevel == FULL_CNT);
        we          = !wen_n && !full;
        waddr       = wbin[ADDR_W-1:0];
        wr_flag     = fwft_q ? !full : full;
        half_full   = (wlevel > PTR_W'(HALF));
        almost_full = ({1'b0, wlevel} + {1'b0, af_off}) >= (PTR_W + 1)'(DEPTH);
    end

    p_full_write_ignored_r6: assert property (@(posedge wclk) disable iff (!mrs_n || !prs_n)
        (full && !wen_n) |=> $stable(wbin));

    p_wgray_one_step_r12: assert property (@(posedge wclk) disable iff (!mrs_n || !prs_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    p_mode_kept_r11: assert property (@(posedge wclk) disable iff (!mrs_n)
        1'b1 |=> $stable(fwft_q));
endmodule

// File: rtl/dm_fifo_rd_ctrl.sv
module dm_fifo_rd_ctrl
    import dm_fifo_pkg::*;
#(
    parameter int WIDTH  = 18,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              rclk,
    input  logic              mrs_n,
    input  logic              prs_n,
    input  logic              fwft_sel,
    input  logic              ren_n,
    input  logic [PTR_W-1:0]  wgray_sync,
    input  logic [PTR_W-1:0]  ae_off,
    input  logic [WIDTH-1:0]  rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rgray,
    output logic [WIDTH-1:0]  dout,
    output logic              rd_flag,
    output logic              almost_empty
);
    rd_state_e        state, state_nx;
    logic             fwft_q;
    logic [PTR_W-1:0] rbin;
    logic [PTR_W-1:0] wbin_sync;
    logic [PTR_W-1:0] rlevel;
    logic             ram_empty;
    logic             fetch;
    logic             hold;

    // state register
    always_ff @(posedge rclk) begin
        if (!mrs_n) begin
            fwft_q <= fwft_sel;
            state  <= fwft_sel ? RD_DRAINED : RD_STD;
            rbin   <= '0;
            rgray  <= '0;
            dout   <= '0;
        end else if (!prs_n) begin
            state  <= fwft_q ? RD_DRAINED : RD_STD;
            rbin   <= '0;
            rgray  <= '0;
            dout   <= '0;
        end else begin
            state <= state_nx;
            if (fetch) begin
                dout  <= rdata;
                rbin  <= rbin + 1'b1;
                rgray <= PTR_W'(bin2gray(32'(rbin + 1'b1)));
            end
        end
    end

    // next state and outputs
    always_comb begin
        wbin_sync = PTR_W'(gray2bin(32'(wgray_sync), PTR_W));
        rlevel    = wbin_sync - rbin;
        ram_empty = (rlevel == '0);
        fetch     = 1'b0;
        state_nx  = state;
        unique case (state)
            RD_STD: begin
                fetch    = !ren_n && !ram_empty;
                state_nx = RD_STD;
            end
            RD_DRAINED: begin
                fetch    = !ram_empty;
                state_nx = ram_empty ? RD_DRAINED : RD_HOLD;
            end
            RD_HOLD: begin
                if (!ren_n) begin
                    fetch    = !ram_empty;
                    state_nx = ram_empty ? RD_DRAINED : RD_HOLD;
                end
            end
            default: state_nx = RD_STD;
        endcase
        hold         = (state == RD_HOLD);
        raddr        = rbin[ADDR_W-1:0];
        rd_flag      = (state == RD_STD) ? ram_empty : hold;
        almost_empty = ({1'b0, rlevel} + (PTR_W + 1)'(hold)) <= {1'b0, ae_off};
    end

    p_empty_read_ignored_r6: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
        (state == RD_STD && ram_empty && !ren_n) |=> ($stable(rbin) && $stable(dout)));

    p_hold_keeps_word_r4: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
        (state == RD_HOLD && ren_n) |=> ($stable(dout) && state == RD_HOLD));

    p_rgray_one_step_r12: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    p_state_matches_mode_r1: assert property (@(posedge rclk) disable iff (!mrs_n)
        (fwft_q == (state != RD_STD)));
endmodule

// File: rtl/dm_fifo.sv
module dm_fifo #(
    parameter int WIDTH  = 18,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              wen_n,
    input  logic [WIDTH-1:0]  din,
    input  logic              rclk,
    input  logic              ren_n,
    output logic [WIDTH-1:0]  dout,
    input  logic              mrs_n,
    input  logic              prs_n,
    input  logic              fwft_sel,
    input  logic [PTR_W-1:0]  ae_off,
    input  logic [PTR_W-1:0]  af_off,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    logic [WIDTH-1:0]  mem [DEPTH];
    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wgray, rgray, wgray_r, rgray_w;
    logic              clr_w, clr_r;

    assign clr_w = !mrs_n || !prs_n;
    assign clr_r = !mrs_n || !prs_n;

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= din;
    end

    dm_fifo_sync2 #(.W(PTR_W)) u_w2r (
        .clk(rclk), .clr(clr_r), .d(wgray), .q(wgray_r)
    );

    dm_fifo_sync2 #(.W(PTR_W)) u_r2w (
        .clk(wclk), .clr(clr_w), .d(rgray), .q(rgray_w)
    );

    dm_fifo_wr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_wr (
        .wclk(wclk), .mrs_n(mrs_n), .prs_n(prs_n), .fwft_sel(fwft_sel),
        .wen_n(wen_n), .rgray_sync(rgray_w), .af_off(af_off),
        .we(we), .waddr(waddr), .wgray(wgray),
        .wr_flag(wr_flag), .half_full(half_full), .almost_full(almost_full)
    );

    dm_fifo_rd_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_rd (
        .rclk(rclk), .mrs_n(mrs_n), .prs_n(prs_n), .fwft_sel(fwft_sel),
        .ren_n(ren_n), .wgray_sync(wgray_r), .ae_off(ae_off),
        .rdata(mem[raddr]), .raddr(raddr), .rgray(rgray), .dout(dout),
        .rd_flag(rd_flag), .almost_empty(almost_empty)
    );
endmodule

// File: tb/tb_dm_fifo.sv
`timescale 1ns/1ps
module tb_dm_fifo;
    localparam int WIDTH = 18;
    localparam int DEPTH = 16;
    localparam int PTR_W = 5;
    localparam int AE    = 3;
    localparam int AF    = 2;

    logic             clk = 1'b0;
    logic             wen_n = 1'b1, ren_n = 1'b1;
    logic             mrs_n = 1'b0, prs_n = 1'b1, fwft_sel = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic             rd_flag, wr_flag, half_full, almost_empty, almost_full;

    int checks = 0;
    int errors = 0;
    int seed_val = 5;
    bit mode_fwft = 0;
    logic [WIDTH-1:0] q[$];
    logic [WIDTH-1:0] last_word = '0;

    always #2 clk = ~clk;

    dm_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
        .wclk(clk), .wen_n(wen_n), .din(din), .rclk(clk), .ren_n(ren_n), .dout(dout),
        .mrs_n(mrs_n), .prs_n(prs_n), .fwft_sel(fwft_sel),
        .ae_off(PTR_W'(AE)), .af_off(PTR_W'(AF)),
        .rd_flag(rd_flag), .wr_flag(wr_flag), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int stored();
        int t = q.size();
        return (mode_fwft && t > 0) ? t - 1 : t;
    endfunction

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    // compare every flag with the queue model
    task automatic check_flags(input string req);
        int t = q.size();
        int s = stored();
        bit e_rd = mode_fwft ? (t > 0) : (t == 0);
        bit e_wr = mode_fwft ? (s < DEPTH) : (s == DEPTH);
        chk(rd_flag == e_rd, {req, " rd_flag"}, rd_flag, e_rd);
        chk(wr_flag == e_wr, {req, " wr_flag R5"}, wr_flag, e_wr);
        chk(half_full == (s > DEPTH / 2), {req, " half_full R7"}, half_full, s > DEPTH / 2);
        chk(almost_empty == (t <= AE), {req, " almost_empty R8"}, almost_empty, t <= AE);
        chk(almost_full == (s >= DEPTH - AF), {req, " almost_full R9"}, almost_full, s >= DEPTH - AF);
        if (mode_fwft && t > 0)
            chk(dout == q[0], {req, " fall-through word R3"}, dout, q[0]);
    endtask

    task automatic write_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seed_val = (seed_val * 37 + 11) % 262139;
            din   = WIDTH'(seed_val);
            wen_n = 1'b0;
            if (stored() < DEPTH) q.push_back(din);
        end
        @(negedge clk);
        wen_n = 1'b1;
        settle();
    endtask

    // standard timing, one word per request
    task automatic read_std(input int n);
        for (int i = 0; i < n; i++) begin
            logic [WIDTH-1:0] exp;
            @(negedge clk);
            ren_n = 1'b0;
            if (q.size() > 0) begin
                exp = q.pop_front();
                last_word = exp;
            end else begin
                exp = last_word;
            end
            @(negedge clk);
            ren_n = 1'b1;
            chk(dout == exp, "R2 R12 R6 standard read data", dout, exp);
        end
        settle();
    endtask

    // fall-through timing, back-to-back acknowledges
    task automatic read_fwft(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(rd_flag == 1'b1, "R4 output valid", rd_flag, 1);
            chk(dout == q[0], "R4 R12 fall-through data", dout, q[0]);
            last_word = q.pop_front();
            ren_n = 1'b0;
        end
        @(negedge clk);
        ren_n = 1'b1;
        if (q.size() == 0) begin
            chk(rd_flag == 1'b0, "R4 valid drops after last", rd_flag, 0);
            chk(dout == last_word, "R4 last word kept", dout, last_word);
        end
        settle();
    endtask

    task automatic master_reset(input bit m);
        @(negedge clk);
        mrs_n = 1'b0;
        fwft_sel = m;
        repeat (3) @(negedge clk);
        mrs_n = 1'b1;
        mode_fwft = m;
        q.delete();
        last_word = '0;
        settle();
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // standard timing
        master_reset(1'b0);
        chk(dout == '0, "R10 dout cleared", dout, 0);
        check_flags("R10 reset std");
        read_std(1);
        chk(rd_flag == 1'b1, "R6 empty read ignored", rd_flag, 1);
        fwft_sel = 1'b1;              // R1: no effect outside master reset
        write_n(3);  check_flags("R8 three words");
        write_n(1);  check_flags("R8 four words");
        write_n(4);  check_flags("R7 eight words");
        write_n(1);  check_flags("R7 nine words");
        write_n(4);  check_flags("R9 thirteen words");
        write_n(1);  check_flags("R9 fourteen words");
        write_n(4);  check_flags("R6 R5 full plus extra writes R1");
        fwft_sel = 1'b0;
        read_std(12); check_flags("R2 after twelve reads");
        read_std(1);  check_flags("R8 three left");
        read_std(3);  check_flags("R2 drained");
        read_std(2);
        chk(dout == last_word, "R6 empty read keeps dout", dout, last_word);
        check_flags("R6 still empty");

        // fall-through timing
        master_reset(1'b1);
        check_flags("R10 reset fwft");
        write_n(1);  check_flags("R3 first word shown");
        write_n(3);  check_flags("R3 four words");
        read_fwft(4); check_flags("R4 drained");
        write_n(10); check_flags("R5 ten words");
        write_n(8);  check_flags("R5 fwft full R6");
        read_fwft(17); check_flags("R4 full drain");

        // partial reset keeps fall-through timing
        write_n(6);
        @(negedge clk); prs_n = 1'b0;
        repeat (3) @(negedge clk); prs_n = 1'b1;
        q.delete();
        settle();
        check_flags("R11 after partial reset");
        write_n(1); check_flags("R11 mode retained");
        read_fwft(1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule